// File: doc/BRIEF.md
# Five-Pin GPIO Port with Mode-Dependent Direction Reset

This block is a five-pin general-purpose I/O port on a byte-wide register bus. Software sets each pin's direction through a write-only direction register and sets output levels through a data latch register. It reads the live pin levels through a read-only pin-state register. Input pins pass through a two-stage synchronizer before software sees them. Each pad gets a separate output value and output enable, so there is no internal tri-state net.

The reset value of the top direction bit depends on the operating mode. A power-on reset or hardware standby sets that bit in modes 1, 4 and 5 and clears it in the other modes. A manual reset and software standby leave the direction register as it is. When the chip-select takeover input is high and the top direction bit is 1, pin 4 carries the chip-select-0 strobe from the bus controller instead of latch data. On entry to software standby, a hold-control input decides whether that bus-control output keeps its last level or is released to high impedance.

Top module: `pinbank_port`

## Requirements
- R1: When `porRstN` is low at a clock edge, the direction register becomes 0x10 if `opMode` is 1, 4 or 5, and 0x00 if `opMode` is 0, 2, 3, 6 or 7. The data latch becomes 0x00 at the same edge.
- R2: While `hwStandby` is high, every clock edge loads the same mode-dependent direction value and clears the data latch. Bus writes have no effect during this time.
- R3: A manual reset (`manRstN` low at an edge) clears the data latch and leaves the direction register unchanged. Software standby changes neither register.
- R4: A write with `busWe` high stores `busWrData[4:0]` at the next edge. Address 0xFEBF selects the direction register and address 0xFF6F selects the data latch. Writes to 0xFF5F or to any other address change nothing.
- R5: Reads are combinational on `busAddr`. Address 0xFEBF returns 0xFF, and 0xFF6F returns bits 7..5 set with the latch in bits 4..0. Address 0xFF5F returns bits 7..5 set with the pin states in bits 4..0. Any other address returns 0x00.
- R6: For pins 3..0, and for pin 4 when it is not taken over, `padOe[i]` equals direction bit i and `padOut[i]` equals latch bit i.
- R7: A pin-state bit equals `padIn[i]` as sampled two clock edges earlier when `padOe[i]` is 0. It equals `padOut[i]` when `padOe[i]` is 1.
- R8: When `csTakeover` is high and direction bit 4 is 1, outside software standby, pin 4 is driven (`padOe[4]`=1) with `csN0`. When direction bit 4 is 0, pin 4 is an input.
- R9: While pin 4 is taken over and `swStandby` is high with `holdBusOut` low, `padOe[4]` is 0. Pins 3..0 are unaffected by software standby.
- R10: While pin 4 is taken over and `swStandby` is high with `holdBusOut` high, pin 4 stays driven with the `csN0` value sampled at the last clock edge before standby began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low, synchronous |
| manRstN | input | 1 | Manual reset, active low, synchronous |
| hwStandby | input | 1 | Hardware standby, active high |
| swStandby | input | 1 | Software standby, active high |
| holdBusOut | input | 1 | 1: bus-control outputs hold in software standby; 0: release |
| opMode | input | 3 | Operating mode number |
| csTakeover | input | 1 | Expanded mode: pin 4 may carry chip-select |
| csN0 | input | 1 | Chip-select-0 level from the bus controller |
| busAddr | input | 16 | Low 16 address bits |
| busWe | input | 1 | Byte write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data |
| padIn | input | 5 | Pad input levels |
| padOut | output | 5 | Pad output values |
| padOe | output | 5 | Pad output enables |

## Verification
A behavioural model in the bench runs alongside the design and is compared against pad enables, enabled pad values and read data on every cycle. The stimulus applies power-on reset in a mode that sets the pin-4 default and in one that clears it, which separates the mode table from a fixed reset value. Different direction masks are paired with changing pad patterns, which tests both the synchronizer delay and the per-bit choice between latch and input. Manual reset, hardware standby and software standby are applied to the same register contents, and the differences between them show which reset kinds touch the direction bits. The chip-select pin is toggled and then taken into standby with both hold settings, which separates the float behaviour from the hold behaviour.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadInit;   // power-on reset or hardware standby
    logic wrDir;      // write direction register
    logic wrLatch;    // write data latch
    logic clrLatch;   // manual reset
    logic captureCs;  // track chip-select level (not in software standby)
    logic csActive;   // pin 4 carries chip-select
    logic csFloat;    // chip-select pin released
    logic csHold;     // chip-select pin holds last level
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_DIR,
    RD_LATCH,
    RD_PINS
  } readSel_t;

endpackage

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PIN_W  = 5,
  parameter int unsigned MODE_W = 3,
  parameter int unsigned CS_PIN = 4,
  parameter logic [ADDR_W-1:0] DIR_ADDR   = 16'hFEBF,
  parameter logic [ADDR_W-1:0] LATCH_ADDR = 16'hFF6F,
  parameter logic [ADDR_W-1:0] PINS_ADDR  = 16'hFF5F,
  parameter logic [(1<<MODE_W)-1:0] CS_INIT_MODES = 8'h32
) (
  input  logic              porRstN,
  input  logic              manRstN,
  input  logic              hwStandby,
  input  logic              swStandby,
  input  logic              holdBusOut,
  input  logic [MODE_W-1:0] opMode,
  input  logic              csTakeover,
  input  logic              csDirBit,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output ctrlStrobes_t      st,
  output readSel_t          readSel,
  output logic [PIN_W-1:0]  initDir
);

  logic hitDir, hitLatch, hitPins;
  logic initPhase;

  assign hitDir    = (busAddr == DIR_ADDR);
  assign hitLatch  = (busAddr == LATCH_ADDR);
  assign hitPins   = (busAddr == PINS_ADDR);
  assign initPhase = !porRstN || hwStandby;

  always_comb begin
    initDir         = '0;
    initDir[CS_PIN] = CS_INIT_MODES[opMode];
  end

  always_comb begin
    st           = '0;
    st.loadInit  = initPhase;
    st.wrDir     = !initPhase && busWe && hitDir;
    st.wrLatch   = !initPhase && busWe && hitLatch;
    st.clrLatch  = !manRstN;
    st.captureCs = !swStandby;
    st.csActive  = csTakeover && csDirBit;
    st.csFloat   = st.csActive && swStandby && !holdBusOut;
    st.csHold    = st.csActive && swStandby && holdBusOut;
  end

  always_comb begin
    if (hitDir)        readSel = RD_DIR;
    else if (hitLatch) readSel = RD_LATCH;
    else if (hitPins)  readSel = RD_PINS;
    else               readSel = RD_NONE;
  end

endmodule

// File: rtl/pinbank_datapath.sv
module pinbank_datapath
  import pinbank_pkg::*;
#(
  parameter int unsigned PIN_W       = 5,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CS_PIN      = 4
) (
  input  logic              clk,
  input  logic              porRstN,
  input  ctrlStrobes_t      st,
  input  readSel_t          readSel,
  input  logic [PIN_W-1:0]  initDir,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              csN0,
  input  logic [PIN_W-1:0]  padIn,
  output logic [DATA_W-1:0] busRdData,
  output logic [PIN_W-1:0]  padOut,
  output logic [PIN_W-1:0]  padOe,
  output logic              csDirBit
);

  localparam int unsigned RSV_W = DATA_W - PIN_W;

  logic [PIN_W-1:0] dirReg;
  logic [PIN_W-1:0] latchReg;
  logic [PIN_W-1:0] syncPipe [SYNC_STAGES];
  logic [PIN_W-1:0] pinState;
  logic             csHeld;

  always_ff @(posedge clk) begin
    if (st.loadInit)   dirReg <= initDir;
    else if (st.wrDir) dirReg <= busWrData[PIN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (st.loadInit || st.clrLatch) latchReg <= '0;
    else if (st.wrLatch)            latchReg <= busWrData[PIN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (st.loadInit)       csHeld <= 1'b1;
    else if (st.captureCs) csHeld <= csN0;
  end

  always_ff @(posedge clk) begin
    if (st.loadInit) syncPipe[0] <= '0;
    else             syncPipe[0] <= padIn;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (st.loadInit) syncPipe[s] <= '0;
      else             syncPipe[s] <= syncPipe[s-1];
    end
  end

  for (genvar i = 0; i < PIN_W; i++) begin : g_pin
    if (i == CS_PIN) begin : g_cs
      assign padOe[i]  = st.csActive ? !st.csFloat : dirReg[i];
      assign padOut[i] = st.csActive ? ((st.csHold || st.csFloat) ? csHeld : csN0)
                                     : latchReg[i];
    end else begin : g_gpio
      assign padOe[i]  = dirReg[i];
      assign padOut[i] = latchReg[i];
    end
    assign pinState[i] = padOe[i] ? padOut[i] : syncPipe[SYNC_STAGES-1][i];
  end

  assign csDirBit = dirReg[CS_PIN];

  always_comb begin
    case (readSel)
      RD_DIR:   busRdData = '1;
      RD_LATCH: busRdData = {{RSV_W{1'b1}}, latchReg};
      RD_PINS:  busRdData = {{RSV_W{1'b1}}, pinState};
      default:  busRdData = '0;
    endcase
  end

  // R2
  init_load_chk: assert property (@(posedge clk) disable iff (!porRstN)
    st.loadInit |=> (dirReg == $past(initDir)) && (latchReg == '0));

  // R3
  manual_keeps_dir_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (st.clrLatch && !st.loadInit && !st.wrDir) |=> $stable(dirReg));

  // R9
  cs_float_chk: assert property (@(posedge clk) disable iff (!porRstN)
    st.csFloat |-> !padOe[CS_PIN]);

  // R10
  cs_hold_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (st.csHold && $past(st.csHold)) |-> ($stable(padOut[CS_PIN]) && padOe[CS_PIN]));

  // R5
  reserved_ones_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (readSel != RD_NONE) |-> (&busRdData[DATA_W-1:PIN_W]));

endmodule

// File: rtl/pinbank_port.sv
module pinbank_port
  import pinbank_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned PIN_W       = 5,
  parameter int unsigned MODE_W      = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CS_PIN      = 4
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              manRstN,
  input  logic              hwStandby,
  input  logic              swStandby,
  input  logic              holdBusOut,
  input  logic [MODE_W-1:0] opMode,
  input  logic              csTakeover,
  input  logic              csN0,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [PIN_W-1:0]  padIn,
  output logic [PIN_W-1:0]  padOut,
  output logic [PIN_W-1:0]  padOe
);

  ctrlStrobes_t     st;
  readSel_t         readSel;
  logic [PIN_W-1:0] initDir;
  logic             csDirBit;

  pinbank_ctrl #(
    .ADDR_W(ADDR_W), .PIN_W(PIN_W), .MODE_W(MODE_W), .CS_PIN(CS_PIN)
  ) u_ctrl (
    .porRstN(porRstN), .manRstN(manRstN), .hwStandby(hwStandby),
    .swStandby(swStandby), .holdBusOut(holdBusOut), .opMode(opMode),
    .csTakeover(csTakeover), .csDirBit(csDirBit), .busAddr(busAddr),
    .busWe(busWe), .st(st), .readSel(readSel), .initDir(initDir)
  );

  pinbank_datapath #(
    .PIN_W(PIN_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES), .CS_PIN(CS_PIN)
  ) u_dp (
    .clk(clk), .porRstN(porRstN), .st(st), .readSel(readSel),
    .initDir(initDir), .busWrData(busWrData), .csN0(csN0), .padIn(padIn),
    .busRdData(busRdData), .padOut(padOut), .padOe(padOe), .csDirBit(csDirBit)
  );

endmodule

// File: tb/pinbank_port_tb.sv
module pinbank_port_tb;

  logic        clk = 1'b0;
  logic        porRstN = 1'b0, manRstN = 1'b1, hwStandby = 1'b0, swStandby = 1'b0;
  logic        holdBusOut = 1'b0, csTakeover = 1'b0, csN0 = 1'b1, busWe = 1'b0;
  logic [2:0]  opMode = 3'd1;
  logic [15:0] busAddr = 16'h0000;
  logic [7:0]  busWrData = 8'h00;
  logic [4:0]  padIn = 5'h00;
  logic [7:0]  busRdData;
  logic [4:0]  padOut, padOe;

  int checks = 0, failures = 0;
  bit done = 0;

  // model state
  logic [4:0] mDir = 5'h00, mLatch = 5'h00, mS1 = 5'h00, mS2 = 5'h00;
  logic       mHeld = 1'b1;

  always #5 clk = ~clk;

  pinbank_port u_dut (
    .clk(clk), .porRstN(porRstN), .manRstN(manRstN), .hwStandby(hwStandby),
    .swStandby(swStandby), .holdBusOut(holdBusOut), .opMode(opMode),
    .csTakeover(csTakeover), .csN0(csN0), .busAddr(busAddr), .busWe(busWe),
    .busWrData(busWrData), .busRdData(busRdData), .padIn(padIn),
    .padOut(padOut), .padOe(padOe)
  );

  task automatic modelClock();
    if (!porRstN || hwStandby) begin
      mDir   = (opMode == 3'd1 || opMode == 3'd4 || opMode == 3'd5) ? 5'h10 : 5'h00;
      mLatch = 5'h00; mS1 = 5'h00; mS2 = 5'h00; mHeld = 1'b1;
    end else begin
      if (!manRstN) mLatch = 5'h00;
      else if (busWe && busAddr == 16'hFF6F) mLatch = busWrData[4:0];
      if (busWe && busAddr == 16'hFEBF) mDir = busWrData[4:0];
      mS2 = mS1; mS1 = padIn;
      if (!swStandby) mHeld = csN0;
    end
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    logic [4:0] eOe, eOut, pins;
    logic [7:0] eRd;
    eOe = mDir; eOut = mLatch;
    if (csTakeover && mDir[4]) begin
      if (swStandby && !holdBusOut) eOe[4] = 1'b0;
      else begin
        eOe[4]  = 1'b1;
        eOut[4] = swStandby ? mHeld : csN0;
      end
    end
    for (int i = 0; i < 5; i++) pins[i] = eOe[i] ? eOut[i] : mS2[i];
    case (busAddr)
      16'hFEBF: eRd = 8'hFF;
      16'hFF6F: eRd = {3'b111, mLatch};
      16'hFF5F: eRd = {3'b111, pins};
      default:  eRd = 8'h00;
    endcase
    check(tag, "padOe", padOe, eOe);
    check(tag, "padOut", padOut & eOe, eOut & eOe);
    check(tag, "busRdData", busRdData, eRd);
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    modelClock();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
    busAddr = a; busWrData = d; busWe = 1'b1;
    step(tag);
    busWe = 1'b0;
  endtask

  initial begin
    // R1: power-on in mode 1 sets direction bit 4
    opMode = 3'd1; porRstN = 1'b0; busAddr = 16'hFF6F;
    step("R1"); step("R1");
    porRstN = 1'b1; step("R1");
    // R1: mode 2 clears it
    opMode = 3'd2; porRstN = 1'b0; step("R1");
    porRstN = 1'b1; step("R1");
    // R4/R5: writes and reads
    wr(16'hFEBF, 8'hEF, "R4");
    wr(16'hFF6F, 8'hA5, "R4");
    busAddr = 16'hFEBF; step("R5");
    busAddr = 16'hFF6F; step("R5");
    wr(16'hFF5F, 8'h1F, "R4");
    wr(16'h1234, 8'h1F, "R4");
    busAddr = 16'h1234; step("R5");
    busAddr = 16'hFF6F; step("R6");
    // R7: input sampling with mixed directions
    wr(16'hFEBF, 8'h0A, "R6");
    busAddr = 16'hFF5F;
    padIn = 5'h15; step("R7");
    padIn = 5'h00; step("R7");
    padIn = 5'h1F; step("R7");
    padIn = 5'h0A; step("R7");
    padIn = 5'h11; step("R7"); step("R7"); step("R7");
    wr(16'hFEBF, 8'h1F, "R6");
    wr(16'hFF6F, 8'h13, "R6");
    busAddr = 16'hFF5F; step("R7");
    // R3: manual reset keeps direction, clears latch
    manRstN = 1'b0; step("R3");
    manRstN = 1'b1; busAddr = 16'hFF6F; step("R3");
    wr(16'hFF6F, 8'h0C, "R3");
    swStandby = 1'b1; step("R3"); step("R3");
    swStandby = 1'b0; step("R3");
    // R2: hardware standby, writes ignored
    opMode = 3'd5; hwStandby = 1'b1;
    wr(16'hFEBF, 8'h07, "R2");
    wr(16'hFF6F, 8'h07, "R2");
    hwStandby = 1'b0; busAddr = 16'hFF5F; step("R2");
    // R8: chip-select takeover
    wr(16'hFF6F, 8'h1F, "R8");
    csTakeover = 1'b1;
    csN0 = 1'b0; step("R8");
    csN0 = 1'b1; step("R8");
    csN0 = 1'b0; step("R8");
    wr(16'hFEBF, 8'h00, "R8");
    padIn = 5'h10; step("R8"); step("R8"); step("R8");
    wr(16'hFEBF, 8'h13, "R8");
    // R9: release in software standby
    csN0 = 1'b0; step("R9");
    holdBusOut = 1'b0; swStandby = 1'b1;
    csN0 = 1'b1; step("R9"); step("R9");
    swStandby = 1'b0; step("R8");
    // R10: hold in software standby
    csN0 = 1'b0; step("R10");
    holdBusOut = 1'b1; swStandby = 1'b1;
    csN0 = 1'b1; step("R10");
    csN0 = 1'b0; step("R10");
    csN0 = 1'b1; step("R10");
    swStandby = 1'b0; step("R8");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule